// File: doc/BRIEF.md
# Endpoint-Zero Automatic Stall Sequencer

This block keeps the two stall flags of a USB control endpoint: one for the transmit (IN) direction and one for the receive (OUT) direction. Firmware picks a policy with three control bits: a control-read stall enable, a control-write stall enable and a sequence-check bit. The packet layer then reports each validated OUT DATA0 packet, OUT DATA1 packet or IN token as a one-cycle strobe. On each strobe the block sets, clears or keeps each stall flag according to the policy. After the data stage of a control transfer, the next host move in the unexpected direction is then stalled without any firmware action.

Firmware can still write either flag directly, and such a write beats the hardware update for that flag in the same cycle. The combination with both stall enables set is flagged as illegal on a registered output. The flags still follow the documented rule for that combination. A hardware reset or a USB bus reset clears both flags. All state changes on the rising clock edge and appears at the outputs one cycle after the inputs are sampled.

Top module: `ep0_autostall`

## Requirements
- R1: While `rst` is high, `tx_stall`, `rx_stall` and `cfg_illegal` are all 0 on the next edge.
- R2: `bus_rst` high clears both stall flags on the next edge. It overrides strobes and firmware writes in that cycle.
- R3: With both stall enables at 0 and any `seq_chk`, an OUT0 or OUT1 strobe clears `tx_stall` and keeps `rx_stall`. An IN strobe clears `rx_stall` and keeps `tx_stall`.
- R4: With only `rd_stall_en` set and `seq_chk` at 0, an OUT0 or OUT1 strobe sets both flags. An IN strobe clears `rx_stall` and keeps `tx_stall`.
- R5: With only `rd_stall_en` set and `seq_chk` at 1, OUT0 clears `tx_stall` and keeps `rx_stall`. OUT1 sets both flags. IN clears `rx_stall` and keeps `tx_stall`.
- R6: With only `wr_stall_en` set and any `seq_chk`, an OUT0 or OUT1 strobe clears `tx_stall` and keeps `rx_stall`. An IN strobe sets both flags.
- R7: With both enables set and `seq_chk` at 0, OUT0 or OUT1 clears `tx_stall` and sets `rx_stall`. IN sets `tx_stall` and clears `rx_stall`.
- R8: With both enables set and `seq_chk` at 1, OUT0 clears `tx_stall` and keeps `rx_stall`. OUT1 clears `tx_stall` and sets `rx_stall`. IN sets `tx_stall` and clears `rx_stall`.
- R9: `cfg_illegal` is 1 in the cycle after a cycle (out of reset) in which `rd_stall_en` and `wr_stall_en` were both 1, and 0 otherwise.
- R10: A firmware write (`fw_tx_we` or `fw_rx_we`) loads its value into that flag and beats the hardware update for that flag only. The other flag still follows the rule.
- R11: When several strobes are high in one cycle, IN wins over both OUT strobes, and OUT0 wins over OUT1. The losing strobes have no effect.
- R12: With no strobe, no firmware write and no reset, both flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_rst | input | 1 | USB bus reset seen, synchronous, clears flags |
| seq_chk | input | 1 | Sequence-check policy bit |
| rd_stall_en | input | 1 | Control-read automatic stall enable |
| wr_stall_en | input | 1 | Control-write automatic stall enable |
| ev_out0 | input | 1 | Strobe: valid OUT DATA0 packet |
| ev_out1 | input | 1 | Strobe: valid OUT DATA1 packet |
| ev_in | input | 1 | Strobe: valid IN token |
| fw_tx_we | input | 1 | Firmware write enable for the transmit stall flag |
| fw_tx_val | input | 1 | Value for the transmit stall flag |
| fw_rx_we | input | 1 | Firmware write enable for the receive stall flag |
| fw_rx_val | input | 1 | Value for the receive stall flag |
| tx_stall | output | 1 | Transmit (IN) stall flag, 1 = stall |
| rx_stall | output | 1 | Receive (OUT) stall flag, 1 = stall |
| cfg_illegal | output | 1 | Both stall enables were set in the previous cycle |

## Verification
Two functions can land on the same edge: a firmware write to a stall flag and a hardware update driven by a packet strobe. Bus reset can also land on top of both. The bench provokes these collisions in directed steps. In one step a strobe that would set both flags meets a write of 0 to only one of them. Another step asserts bus reset together with a write of 1 and a strobe. Random cycles then mix all inputs, and the two flags are judged separately against a behavioural model on every clock. Colliding strobes are checked the same way: the model picks the winner by the stated order, and the bench confirms that the losers changed nothing.

// File: rtl/ep0_autostall_pkg.sv
package ep0_autostall_pkg;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'd0,
    ACT_CLR  = 2'd1,
    ACT_SET  = 2'd2
  } flag_act_e;

  typedef enum logic [1:0] {
    EVK_NONE = 2'd0,
    EVK_OUT0 = 2'd1,
    EVK_OUT1 = 2'd2,
    EVK_IN   = 2'd3
  } ev_kind_e;

  typedef struct packed {
    flag_act_e tx;
    flag_act_e rx;
  } act_pair_t;

  localparam int unsigned NUM_FLAGS = 2;
  localparam int unsigned IDX_TX    = 0;
  localparam int unsigned IDX_RX    = 1;

endpackage

// File: rtl/ep0_evt_arb.sv
module ep0_evt_arb
  import ep0_autostall_pkg::*;
(
  input  logic     ev_out0,
  input  logic     ev_out1,
  input  logic     ev_in,
  output ev_kind_e kind
);

  always_comb begin
    if (ev_in)        kind = EVK_IN;
    else if (ev_out0) kind = EVK_OUT0;
    else if (ev_out1) kind = EVK_OUT1;
    else              kind = EVK_NONE;
  end

endmodule

// File: rtl/ep0_stall_rules.sv
module ep0_stall_rules
  import ep0_autostall_pkg::*;
(
  input  logic      seq_chk,
  input  logic      rd_en,
  input  logic      wr_en,
  input  ev_kind_e  kind,
  output act_pair_t act
);

  always_comb begin
    act = '{tx: ACT_KEEP, rx: ACT_KEEP};
    unique case ({wr_en, rd_en})
      2'b00: begin
        if (kind == EVK_OUT0 || kind == EVK_OUT1) act = '{tx: ACT_CLR, rx: ACT_KEEP};
        else if (kind == EVK_IN)                  act = '{tx: ACT_KEEP, rx: ACT_CLR};
      end
      2'b01: begin
        if (kind == EVK_OUT0)
          act = seq_chk ? '{tx: ACT_CLR, rx: ACT_KEEP} : '{tx: ACT_SET, rx: ACT_SET};
        else if (kind == EVK_OUT1) act = '{tx: ACT_SET, rx: ACT_SET};
        else if (kind == EVK_IN)   act = '{tx: ACT_KEEP, rx: ACT_CLR};
      end
      2'b10: begin
        if (kind == EVK_OUT0 || kind == EVK_OUT1) act = '{tx: ACT_CLR, rx: ACT_KEEP};
        else if (kind == EVK_IN)                  act = '{tx: ACT_SET, rx: ACT_SET};
      end
      default: begin
        if (kind == EVK_OUT0)
          act = seq_chk ? '{tx: ACT_CLR, rx: ACT_KEEP} : '{tx: ACT_CLR, rx: ACT_SET};
        else if (kind == EVK_OUT1) act = '{tx: ACT_CLR, rx: ACT_SET};
        else if (kind == EVK_IN)   act = '{tx: ACT_SET, rx: ACT_CLR};
      end
    endcase
  end

endmodule

// File: rtl/ep0_stall_flag.sv
module ep0_stall_flag
  import ep0_autostall_pkg::*;
#(
  parameter bit RST_VAL = 1'b0
)(
  input  logic      clk,
  input  logic      rst,
  input  logic      bus_rst,
  input  logic      fw_we,
  input  logic      fw_val,
  input  flag_act_e act,
  output logic      q
);

  always_ff @(posedge clk) begin
    if (rst || bus_rst) begin
      q <= RST_VAL;
    end else if (fw_we) begin
      q <= fw_val;
    end else begin
      case (act)
        ACT_SET: q <= 1'b1;
        ACT_CLR: q <= 1'b0;
        default: q <= q;
      endcase
    end
  end

  assert_bus_reset_clears_R2: assert property (@(posedge clk) disable iff (rst)
    bus_rst |=> (q == RST_VAL));

  assert_fw_beats_hw_R10: assert property (@(posedge clk) disable iff (rst)
    (fw_we && !bus_rst) |=> (q == $past(fw_val)));

  assert_idle_holds_R12: assert property (@(posedge clk) disable iff (rst)
    (!bus_rst && !fw_we && act == ACT_KEEP) |=> $stable(q));

  assert_set_applies_R7: assert property (@(posedge clk) disable iff (rst)
    (!bus_rst && !fw_we && act == ACT_SET) |=> q);

  assert_clr_applies_R3: assert property (@(posedge clk) disable iff (rst)
    (!bus_rst && !fw_we && act == ACT_CLR) |=> !q);

endmodule

// File: rtl/ep0_autostall.sv
module ep0_autostall
  import ep0_autostall_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bus_rst,
  input  logic seq_chk,
  input  logic rd_stall_en,
  input  logic wr_stall_en,
  input  logic ev_out0,
  input  logic ev_out1,
  input  logic ev_in,
  input  logic fw_tx_we,
  input  logic fw_tx_val,
  input  logic fw_rx_we,
  input  logic fw_rx_val,
  output logic tx_stall,
  output logic rx_stall,
  output logic cfg_illegal
);

  ev_kind_e  kind;
  act_pair_t act;

  logic [NUM_FLAGS-1:0] we_v, val_v, q_v;
  flag_act_e            act_v [NUM_FLAGS];

  ep0_evt_arb u_arb (
    .ev_out0 (ev_out0),
    .ev_out1 (ev_out1),
    .ev_in   (ev_in),
    .kind    (kind)
  );

  ep0_stall_rules u_rules (
    .seq_chk (seq_chk),
    .rd_en   (rd_stall_en),
    .wr_en   (wr_stall_en),
    .kind    (kind),
    .act     (act)
  );

  assign we_v[IDX_TX]  = fw_tx_we;
  assign we_v[IDX_RX]  = fw_rx_we;
  assign val_v[IDX_TX] = fw_tx_val;
  assign val_v[IDX_RX] = fw_rx_val;
  assign act_v[IDX_TX] = act.tx;
  assign act_v[IDX_RX] = act.rx;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    ep0_stall_flag #(.RST_VAL(1'b0)) u_flag (
      .clk     (clk),
      .rst     (rst),
      .bus_rst (bus_rst),
      .fw_we   (we_v[g]),
      .fw_val  (val_v[g]),
      .act     (act_v[g]),
      .q       (q_v[g])
    );
  end

  assign tx_stall = q_v[IDX_TX];
  assign rx_stall = q_v[IDX_RX];

  always_ff @(posedge clk) begin
    if (rst) cfg_illegal <= 1'b0;
    else     cfg_illegal <= rd_stall_en & wr_stall_en;
  end

  assert_illegal_flag_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cfg_illegal == $past(rd_stall_en && wr_stall_en)));

  assert_in_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (ev_in && ev_out0 && ev_out1 && wr_stall_en && !rd_stall_en &&
     !bus_rst && !fw_tx_we && !fw_rx_we) |=> (tx_stall && rx_stall));

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!tx_stall && !rx_stall && !cfg_illegal));

endmodule

// File: tb/ep0_autostall_bench.sv
`timescale 1ns/1ps
module ep0_autostall_bench;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, bus_rst, seq_chk, rd_stall_en, wr_stall_en;
  logic ev_out0, ev_out1, ev_in, fw_tx_we, fw_tx_val, fw_rx_we, fw_rx_val;
  logic tx_stall, rx_stall, cfg_illegal;

  ep0_autostall u_ep0_autostall (.*);

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic m_tx = 0, m_rx = 0, m_ill = 0;

  task automatic check(input string req, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: integer codes, -1 = keep, 0 = clear, 1 = set
  task automatic model_step();
    int ntx, nrx;
    int pkt;  // 0 none, 1 out0, 2 out1, 3 in
    ntx = -1; nrx = -1;
    pkt = ev_in ? 3 : ev_out0 ? 1 : ev_out1 ? 2 : 0;
    if (rst) begin
      m_tx = 0; m_rx = 0; m_ill = 0;
      return;
    end
    m_ill = rd_stall_en & wr_stall_en;
    if (bus_rst) begin
      m_tx = 0; m_rx = 0;
      return;
    end
    if (pkt == 3) begin
      if (wr_stall_en && rd_stall_en)  begin ntx = 1; nrx = 0; end
      else if (wr_stall_en)            begin ntx = 1; nrx = 1; end
      else                             begin nrx = 0; end
    end else if (pkt != 0) begin
      if (!rd_stall_en) begin
        ntx = 0;
      end else if (!wr_stall_en) begin
        if (seq_chk && pkt == 1) ntx = 0;
        else begin ntx = 1; nrx = 1; end
      end else begin
        ntx = 0;
        if (!(seq_chk && pkt == 1)) nrx = 1;
      end
    end
    if (fw_tx_we) m_tx = fw_tx_val; else if (ntx >= 0) m_tx = ntx[0];
    if (fw_rx_we) m_rx = fw_rx_val; else if (nrx >= 0) m_rx = nrx[0];
  endtask

  task automatic step(input string req,
                      input logic s, input logic rd, input logic wr,
                      input logic o0, input logic o1, input logic in_,
                      input logic txwe = 0, input logic txv = 0,
                      input logic rxwe = 0, input logic rxv = 0,
                      input logic brst = 0, input logic r = 0);
    seq_chk = s; rd_stall_en = rd; wr_stall_en = wr;
    ev_out0 = o0; ev_out1 = o1; ev_in = in_;
    fw_tx_we = txwe; fw_tx_val = txv; fw_rx_we = rxwe; fw_rx_val = rxv;
    bus_rst = brst; rst = r;
    model_step();
    @(negedge clk);
    check(req, tx_stall, m_tx, "tx_stall");
    check(req, rx_stall, m_rx, "rx_stall");
    check(req, cfg_illegal, m_ill, "cfg_illegal");
  endtask

  // preload both flags to a given pair via firmware writes
  task automatic preload(input string req, input logic t, input logic x);
    step(req, 0, 0, 0, 0, 0, 0, 1, t, 1, x);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    {bus_rst, seq_chk, rd_stall_en, wr_stall_en, ev_out0, ev_out1, ev_in} = '0;
    {fw_tx_we, fw_tx_val, fw_rx_we, fw_rx_val} = '0;
    rst = 1;
    @(negedge clk);
    // R1: reset with illegal config and writes present
    step("R1", 1, 1, 1, 0, 0, 1, 1, 1, 1, 1, 0, 1);
    step("R1", 0, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 1);

    // R3: no enables, both seq values
    for (int s = 0; s < 2; s++) begin
      preload("R3", 1, 1);
      step("R3", s[0], 0, 0, 1, 0, 0);
      preload("R3", 1, 1);
      step("R3", s[0], 0, 0, 0, 1, 0);
      preload("R3", 1, 1);
      step("R3", s[0], 0, 0, 0, 0, 1);
    end
    // R4
    preload("R4", 0, 0); step("R4", 0, 1, 0, 1, 0, 0);
    preload("R4", 0, 0); step("R4", 0, 1, 0, 0, 1, 0);
    preload("R4", 1, 1); step("R4", 0, 1, 0, 0, 0, 1);
    // R5
    preload("R5", 1, 1); step("R5", 1, 1, 0, 1, 0, 0);
    preload("R5", 0, 0); step("R5", 1, 1, 0, 0, 1, 0);
    preload("R5", 0, 1); step("R5", 1, 1, 0, 0, 0, 1);
    // R6
    for (int s = 0; s < 2; s++) begin
      preload("R6", 1, 1); step("R6", s[0], 0, 1, 1, 0, 0);
      preload("R6", 1, 0); step("R6", s[0], 0, 1, 0, 1, 0);
      preload("R6", 0, 0); step("R6", s[0], 0, 1, 0, 0, 1);
    end
    // R7 and R9
    preload("R7", 1, 0); step("R7", 0, 1, 1, 1, 0, 0);
    preload("R7", 1, 0); step("R7", 0, 1, 1, 0, 1, 0);
    preload("R7", 0, 1); step("R7", 0, 1, 1, 0, 0, 1);
    step("R9", 0, 0, 1, 0, 0, 0);
    // R8
    preload("R8", 1, 0); step("R8", 1, 1, 1, 1, 0, 0);
    preload("R8", 1, 0); step("R8", 1, 1, 1, 0, 1, 0);
    preload("R8", 0, 1); step("R8", 1, 1, 1, 0, 0, 1);
    // R10: strobe would set both; firmware writes 0 to tx only
    preload("R10", 0, 0); step("R10", 0, 0, 1, 0, 0, 1, 1, 0, 0, 0);
    preload("R10", 0, 0); step("R10", 0, 0, 1, 0, 0, 1, 0, 0, 1, 0);
    // R11: all strobes together, write-stall only -> IN wins (both set)
    preload("R11", 0, 0); step("R11", 0, 0, 1, 1, 1, 1);
    // out0 + out1 with read-stall and seq: OUT0 wins -> tx clear, rx kept
    preload("R11", 1, 1); step("R11", 1, 1, 0, 1, 1, 0);
    // R12: idle holds
    preload("R12", 1, 0);
    step("R12", 1, 1, 1, 0, 0, 0); step("R12", 0, 1, 0, 0, 0, 0);
    // R2: bus reset beats write and strobe
    preload("R2", 1, 1); step("R2", 0, 0, 1, 0, 0, 1, 1, 1, 1, 1, 1);

    // random mix, all requirements R2..R12
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] r;
      r = 12'($urandom);
      step("RND", r[0], r[1], r[2], r[3], r[4], r[5], r[6], r[7], r[8], r[9],
           (r[11:10] == 2'b11) && r[0]);
    end
    finish_run();
  end

endmodule